// File: doc/BRIEF.md
# Frequency Sweep and List Sequencer

This block produces the stream of frequency words that drives a synthesizer's tuning logic. Words are 56 bits wide and count millihertz. Two sources are available. The sweep source walks a linear ramp from a start word toward a stop word in equal steps. The ramp rises when the stop word is at least the start word and falls otherwise. The list source reads a buffer of points that was loaded beforehand through a simple write port.

Each point is held for a dwell time given in half-millisecond units. A parameter sets how many clock cycles make up one unit. A traversal cycle either restarts at the first point (sawtooth) or turns around at the last point and walks back to the first (triangular). A cycle count of zero repeats the traversal forever. A nonzero count stops the sequencer after that many cycles, holding the final point.

A run is started by a single-cycle software strobe or by a falling edge on an asynchronous trigger pin. The pin passes through a two-flop synchronizer before edge detection. In step-on-trigger mode each further pin edge advances one point and the dwell timer is not used. A `running` output reports that a triggered run is in progress.

Top module: `fseq_top`

## Requirements
- R1: After reset `running` is 0 and `freqOut` is 0.
- R2: In sweep mode with stop >= start, the points are start, start+step, start+2*step, and so on, up to the last point that does not exceed stop. A step of zero gives the single point start.
- R3: In sweep mode with stop < start, the points fall by step from start, down to the last point that is not below stop.
- R4: In list mode the points are buffer entries 0 through len-1, where len is `listLen`. A len of 0 is taken as 1, and a len above the buffer depth is taken as the depth.
- R5: In free-run mode each point stays on `freqOut` for exactly TICKS_PER_UNIT × dwell cycles. A dwell of 0 counts as 1.
- R6: Sawtooth (`triangle`=0) continues from the last point to the first. Triangular (`triangle`=1) steps back from the last point toward the first. The next cycle then resumes at the second point. A single-point sequence repeats its point.
- R7: With `cycleCount`=N>0, the run ends after the final point of the Nth cycle has dwelt. `running` falls and `freqOut` holds that point. With N=0 the run never ends by itself. While idle, `freqOut` does not change.
- R8: With `hwTrigSel`=1, a high-to-low transition on `trigPin` starts a run. It takes effect on the third rising clock edge after the pin falls: two synchronizer flops and one edge-detect flop. A rising transition does nothing.
- R9: With `hwTrigSel`=0, a one-cycle pulse on `softTrig` starts a run from idle. In free-run mode, a trigger event from the selected source while running stops the run and holds `freqOut`.
- R10: With `stepOnTrig`=1 and `hwTrigSel`=1, the first pin edge starts the run. Each later edge advances exactly one point. Without an edge the point never changes. The cycle count applies as in R7.
- R11: With `stepOnTrig`=1 and `hwTrigSel`=0, `softTrig` is ignored: `running` stays 0 and `freqOut` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| listMode | input | 1 | 0 = sweep source, 1 = list source |
| triangle | input | 1 | 0 = sawtooth traversal, 1 = triangular traversal |
| hwTrigSel | input | 1 | 0 = software strobe, 1 = trigger pin |
| stepOnTrig | input | 1 | 1 = advance one point per trigger instead of by dwell |
| softTrig | input | 1 | Single-cycle software trigger strobe |
| trigPin | input | 1 | Asynchronous trigger pin, active on falling edge |
| startFreq | input | FREQ_W | Sweep start word (mHz) |
| stopFreq | input | FREQ_W | Sweep stop word (mHz) |
| stepFreq | input | FREQ_W | Sweep step magnitude (mHz) |
| dwellUnits | input | DWELL_W | Dwell per point in half-millisecond units |
| cycleCount | input | CYC_W | Cycles to run, 0 = forever |
| listLen | input | ADDR_W+1 | Number of list points in use |
| listWrEn | input | 1 | List buffer write enable |
| listWrAddr | input | ADDR_W | List buffer write index |
| listWrData | input | FREQ_W | List buffer write data (mHz) |
| freqOut | output | FREQ_W | Current frequency word (mHz) |
| running | output | 1 | A triggered run is in progress |

## Verification
The assertions assume that the configuration inputs and the list buffer stay unchanged while `running` is high. The sweep range and traversal properties are only meaningful under that condition. They also assume that `softTrig` is a single-cycle strobe, and that step-on-trigger is combined only with the pin source when a run is expected. The stimulus changes modes, words and buffer contents only while the sequencer is idle. It drives every input half a cycle away from the sampling edge. It holds the trigger pin at each level for several cycles, so that every edge passes through the synchronizer.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  // Strobes from the control to the datapath; at most one is high per cycle.
  typedef struct packed {
    logic loadFirst;  // reload the first point of the sequence
    logic stepFwd;    // move one point toward the far end
    logic stepBack;   // move one point back toward the first point
  } seq_strobe_t;

  // Position flags from the datapath back to the control.
  typedef struct packed {
    logic atLast;     // current point is the far end of the sequence
    logic atFirst;    // current point is the first point
  } seq_pos_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DWELL = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;

endpackage

// File: rtl/fseq_trig_sync.sv
module fseq_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic fallPulse
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chainQ;

  // Idle level of the pin is high, so the chain resets high (no false edge).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chainQ <= '1;
    else       chainQ <= {chainQ[CHAIN_W-2:0], pinIn};
  end

  // Falling edge: the older sample is high and the newer one is low.
  assign fallPulse = chainQ[CHAIN_W-1] & ~chainQ[CHAIN_W-2];

endmodule

// File: rtl/fseq_datapath.sv
module fseq_datapath
  import fseq_pkg::*;
#(
  parameter int FREQ_W     = 56,
  parameter int LIST_DEPTH = 1024,
  parameter int ADDR_W     = $clog2(LIST_DEPTH),
  parameter int LEN_W      = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              listMode,
  input  logic [FREQ_W-1:0] startFreq,
  input  logic [FREQ_W-1:0] stopFreq,
  input  logic [FREQ_W-1:0] stepFreq,
  input  logic [LEN_W-1:0]  listLen,
  input  logic              listWrEn,
  input  logic [ADDR_W-1:0] listWrAddr,
  input  logic [FREQ_W-1:0] listWrData,
  input  seq_strobe_t       strobe,
  output seq_pos_t          pos,
  output logic [FREQ_W-1:0] freqOut
);
  localparam logic [LEN_W-1:0] DEPTH_LEN = LEN_W'(LIST_DEPTH);

  logic [FREQ_W-1:0] listMem [LIST_DEPTH];
  logic [FREQ_W-1:0] freqQ;
  logic [ADDR_W-1:0] idxQ;
  logic [ADDR_W-1:0] idxNext, idxPrev, lastIdx;
  logic [LEN_W-1:0]  usedLen;

  // Sweep arithmetic
  logic              sweepDown;
  logic [FREQ_W-1:0] distToEnd, distToStart;
  logic [FREQ_W-1:0] sweepFwd, sweepBack;
  logic              sweepLast, sweepFirst;
  logic              listLast, listFirst;

  // List buffer write port
  always_ff @(posedge clk) begin
    if (listWrEn) listMem[listWrAddr] <= listWrData;
  end

  // Effective list length: 0 counts as 1, anything above depth is clamped.
  always_comb begin
    if (listLen == '0)            usedLen = LEN_W'(1);
    else if (listLen > DEPTH_LEN) usedLen = DEPTH_LEN;
    else                          usedLen = listLen;
    lastIdx = ADDR_W'(usedLen - LEN_W'(1));
  end

  assign idxNext = idxQ + ADDR_W'(1);
  assign idxPrev = idxQ - ADDR_W'(1);

  assign listLast  = (idxQ == lastIdx);
  assign listFirst = (idxQ == '0);

  // Ramp direction follows the ordering of the two end words.
  assign sweepDown   = (stopFreq < startFreq);
  assign distToEnd   = sweepDown ? (freqQ - stopFreq)  : (stopFreq - freqQ);
  assign distToStart = sweepDown ? (startFreq - freqQ) : (freqQ - startFreq);
  assign sweepFwd    = sweepDown ? (freqQ - stepFreq)  : (freqQ + stepFreq);
  assign sweepBack   = sweepDown ? (freqQ + stepFreq)  : (freqQ - stepFreq);

  // A zero step collapses the ramp to a single point.
  assign sweepLast  = (stepFreq == '0) || (distToEnd   < stepFreq);
  assign sweepFirst = (stepFreq == '0) || (distToStart < stepFreq);

  assign pos.atLast  = listMode ? listLast  : sweepLast;
  assign pos.atFirst = listMode ? listFirst : sweepFirst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freqQ <= '0;
      idxQ  <= '0;
    end else if (strobe.loadFirst) begin
      freqQ <= listMode ? listMem[0] : startFreq;
      idxQ  <= '0;
    end else if (strobe.stepFwd) begin
      freqQ <= listMode ? listMem[idxNext] : sweepFwd;
      idxQ  <= idxNext;
    end else if (strobe.stepBack) begin
      freqQ <= listMode ? listMem[idxPrev] : sweepBack;
      idxQ  <= idxPrev;
    end
  end

  assign freqOut = freqQ;

endmodule

// File: rtl/fseq_control.sv
module fseq_control
  import fseq_pkg::*;
#(
  parameter int DWELL_W        = 32,
  parameter int CYC_W          = 32,
  parameter int TICKS_PER_UNIT = 100000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               triangle,
  input  logic               hwTrigSel,
  input  logic               stepOnTrig,
  input  logic               softTrig,
  input  logic               trigFall,
  input  logic [DWELL_W-1:0] dwellUnits,
  input  logic [CYC_W-1:0]   cycleCount,
  input  seq_pos_t           pos,
  output seq_strobe_t        strobe,
  output logic               running
);
  localparam int TICK_W = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_UNIT - 1);

  seq_state_t         stateQ, stateD;
  logic               runQ, runD;
  logic               backQ, backD;
  logic [CYC_W-1:0]   cycQ, cycD;
  logic [TICK_W-1:0]  tickQ;
  logic [DWELL_W-1:0] unitQ;
  logic [DWELL_W-1:0] dwellEff;

  logic trigEvt, trigOk, dwellDone, advance, clrDwell;
  logic endCycle, lastCycle, finiteRun;

  assign trigEvt   = hwTrigSel ? trigFall : softTrig;
  assign trigOk    = hwTrigSel | ~stepOnTrig;   // software strobe cannot drive stepping
  assign dwellEff  = (dwellUnits == '0) ? DWELL_W'(1) : dwellUnits;
  assign dwellDone = (tickQ == TICK_LAST) && (unitQ == dwellEff - DWELL_W'(1));
  assign finiteRun = (cycleCount != '0);
  assign lastCycle = finiteRun && (cycQ == CYC_W'(1));

  // A cycle ends on the first point while walking back, or on the far end
  // when there is nothing to walk back over.
  assign endCycle = backQ ? pos.atFirst
                          : (pos.atLast && (!triangle || pos.atFirst));

  always_comb begin
    stateD   = stateQ;
    runD     = runQ;
    backD    = backQ;
    cycD     = cycQ;
    strobe   = '0;
    advance  = 1'b0;
    clrDwell = 1'b0;

    unique case (stateQ)
      ST_IDLE: begin
        if (trigEvt && trigOk) begin
          strobe.loadFirst = 1'b1;
          runD     = 1'b1;
          backD    = 1'b0;
          cycD     = cycleCount;
          clrDwell = 1'b1;
          stateD   = stepOnTrig ? ST_WAIT : ST_DWELL;
        end
      end
      ST_DWELL: begin
        if (trigEvt) begin
          runD   = 1'b0;
          stateD = ST_IDLE;
        end else if (dwellDone) begin
          advance = 1'b1;
        end
      end
      ST_WAIT: begin
        if (trigEvt) advance = 1'b1;
      end
      default: stateD = ST_IDLE;
    endcase

    if (advance) begin
      clrDwell = 1'b1;
      if (endCycle) begin
        if (lastCycle) begin
          runD   = 1'b0;
          stateD = ST_IDLE;
        end else begin
          if (finiteRun) cycD = cycQ - CYC_W'(1);
          backD = 1'b0;
          if (backQ) strobe.stepFwd   = 1'b1;
          else       strobe.loadFirst = 1'b1;
        end
      end else if (!backQ) begin
        if (pos.atLast) begin
          backD = 1'b1;
          strobe.stepBack = 1'b1;
        end else begin
          strobe.stepFwd = 1'b1;
        end
      end else begin
        strobe.stepBack = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      runQ   <= 1'b0;
      backQ  <= 1'b0;
      cycQ   <= '0;
    end else begin
      stateQ <= stateD;
      runQ   <= runD;
      backQ  <= backD;
      cycQ   <= cycD;
    end
  end

  // Dwell timer: unit prescaler followed by a unit counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickQ <= '0;
      unitQ <= '0;
    end else if (clrDwell || stateQ != ST_DWELL) begin
      tickQ <= '0;
      unitQ <= '0;
    end else if (tickQ == TICK_LAST) begin
      tickQ <= '0;
      unitQ <= unitQ + DWELL_W'(1);
    end else begin
      tickQ <= tickQ + TICK_W'(1);
    end
  end

  assign running = runQ;

endmodule

// File: rtl/fseq_top.sv
module fseq_top
  import fseq_pkg::*;
#(
  parameter int FREQ_W         = 56,
  parameter int LIST_DEPTH     = 1024,
  parameter int DWELL_W        = 32,
  parameter int CYC_W          = 32,
  parameter int TICKS_PER_UNIT = 100000,
  parameter int SYNC_STAGES    = 2,
  localparam int ADDR_W        = $clog2(LIST_DEPTH),
  localparam int LEN_W         = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               listMode,
  input  logic               triangle,
  input  logic               hwTrigSel,
  input  logic               stepOnTrig,
  input  logic               softTrig,
  input  logic               trigPin,
  input  logic [FREQ_W-1:0]  startFreq,
  input  logic [FREQ_W-1:0]  stopFreq,
  input  logic [FREQ_W-1:0]  stepFreq,
  input  logic [DWELL_W-1:0] dwellUnits,
  input  logic [CYC_W-1:0]   cycleCount,
  input  logic [LEN_W-1:0]   listLen,
  input  logic               listWrEn,
  input  logic [ADDR_W-1:0]  listWrAddr,
  input  logic [FREQ_W-1:0]  listWrData,
  output logic [FREQ_W-1:0]  freqOut,
  output logic               running
);
  logic        trigFall;
  seq_strobe_t strobe;
  seq_pos_t    pos;

  fseq_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (trigPin),
    .fallPulse (trigFall)
  );

  fseq_control #(
    .DWELL_W        (DWELL_W),
    .CYC_W          (CYC_W),
    .TICKS_PER_UNIT (TICKS_PER_UNIT)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .triangle   (triangle),
    .hwTrigSel  (hwTrigSel),
    .stepOnTrig (stepOnTrig),
    .softTrig   (softTrig),
    .trigFall   (trigFall),
    .dwellUnits (dwellUnits),
    .cycleCount (cycleCount),
    .pos        (pos),
    .strobe     (strobe),
    .running    (running)
  );

  fseq_datapath #(
    .FREQ_W     (FREQ_W),
    .LIST_DEPTH (LIST_DEPTH),
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .listMode   (listMode),
    .startFreq  (startFreq),
    .stopFreq   (stopFreq),
    .stepFreq   (stepFreq),
    .listLen    (listLen),
    .listWrEn   (listWrEn),
    .listWrAddr (listWrAddr),
    .listWrData (listWrData),
    .strobe     (strobe),
    .pos        (pos),
    .freqOut    (freqOut)
  );

endmodule

// File: rtl/fseq_checker.sv
module fseq_checker
  import fseq_pkg::*;
#(
  parameter int FREQ_W = 56
) (
  input logic              clk,
  input logic              rstN,
  input logic              running,
  input logic [FREQ_W-1:0] freqOut,
  input logic              listMode,
  input logic [FREQ_W-1:0] startFreq,
  input logic [FREQ_W-1:0] stopFreq,
  input logic              hwTrigSel,
  input logic              stepOnTrig,
  input logic              softTrig,
  input logic              trigFall,
  input seq_strobe_t       strobe
);

  // R7: an idle sequencer holds its output word
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> $stable(freqOut));

  // R2: a rising ramp stays between its end words
  assert_rise_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (running && !listMode && stopFreq >= startFreq)
      |-> (freqOut >= startFreq && freqOut <= stopFreq));

  // R3: a falling ramp stays between its end words
  assert_fall_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (running && !listMode && stopFreq < startFreq)
      |-> (freqOut <= startFreq && freqOut >= stopFreq));

  // R8: a run only begins after an event from the selected source
  assert_start_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(hwTrigSel ? trigFall : softTrig));

  // R11: the software strobe never starts a stepping run
  assert_soft_step_block_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(hwTrigSel || !stepOnTrig));

  // R6: the control issues at most one movement per cycle
  assert_single_move_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadFirst, strobe.stepFwd, strobe.stepBack}));

endmodule

bind fseq_top fseq_checker #(.FREQ_W(FREQ_W)) u_fseq_checker (
  .clk        (clk),
  .rstN       (rstN),
  .running    (running),
  .freqOut    (freqOut),
  .listMode   (listMode),
  .startFreq  (startFreq),
  .stopFreq   (stopFreq),
  .hwTrigSel  (hwTrigSel),
  .stepOnTrig (stepOnTrig),
  .softTrig   (softTrig),
  .trigFall   (trigFall),
  .strobe     (strobe)
);

// File: tb/fseq_top_bench.sv
`timescale 1ns/1ps
module fseq_top_bench;
  localparam int FW    = 56;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int LW    = 5;
  localparam int DW    = 16;
  localparam int CW    = 16;
  localparam int TPU   = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic          listMode = 0, triangle = 0, hwTrigSel = 0, stepOnTrig = 0;
  logic          softTrig = 0, trigPin = 1;
  logic [FW-1:0] startFreq = '0, stopFreq = '0, stepFreq = '0;
  logic [DW-1:0] dwellUnits = '0;
  logic [CW-1:0] cycleCount = '0;
  logic [LW-1:0] listLen = '0;
  logic          listWrEn = 0;
  logic [AW-1:0] listWrAddr = '0;
  logic [FW-1:0] listWrData = '0;
  logic [FW-1:0] freqOut;
  logic          running;

  fseq_top #(
    .FREQ_W(FW), .LIST_DEPTH(DEPTH), .DWELL_W(DW), .CYC_W(CW),
    .TICKS_PER_UNIT(TPU), .SYNC_STAGES(2)
  ) u_fseq_top (
    .clk(clk), .rstN(rstN), .listMode(listMode), .triangle(triangle),
    .hwTrigSel(hwTrigSel), .stepOnTrig(stepOnTrig), .softTrig(softTrig),
    .trigPin(trigPin), .startFreq(startFreq), .stopFreq(stopFreq),
    .stepFreq(stepFreq), .dwellUnits(dwellUnits), .cycleCount(cycleCount),
    .listLen(listLen), .listWrEn(listWrEn), .listWrAddr(listWrAddr),
    .listWrData(listWrData), .freqOut(freqOut), .running(running)
  );

  int    checks = 0;
  int    fails  = 0;
  string curReq = "R1";

  task automatic check(string req, string what, logic [FW-1:0] act, logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [FW-1:0] refMem [DEPTH];
  logic [FW-1:0] seqQ [$];
  logic [FW-1:0] mFreq = '0;
  logic          mRun = 0;
  int            mState = 0;   // 0 idle, 1 timed, 2 stepping
  int            mPos = 0, mDwell = 0, mCyc = 0;
  logic [2:0]    mPin = 3'b111;

  function automatic void buildSeq();
    logic [FW-1:0] fwd [$];
    logic [FW:0]   f;
    int            n;
    seqQ.delete();
    if (listMode) begin
      n = (listLen == 0) ? 1 : ((listLen > DEPTH) ? DEPTH : int'(listLen));
      for (int i = 0; i < n; i++) fwd.push_back(refMem[i]);
    end else begin
      f = {1'b0, startFreq};
      forever begin
        fwd.push_back(f[FW-1:0]);
        if (stepFreq == 0) break;
        if (stopFreq >= startFreq) begin
          if ({1'b0, stopFreq} - f < {1'b0, stepFreq}) break;
          f = f + stepFreq;
        end else begin
          if (f - {1'b0, stopFreq} < {1'b0, stepFreq}) break;
          f = f - stepFreq;
        end
      end
    end
    foreach (fwd[i]) seqQ.push_back(fwd[i]);
    if (triangle)
      for (int i = fwd.size() - 2; i >= 0; i--) seqQ.push_back(fwd[i]);
  endfunction

  function automatic void modelAdvance();
    mDwell = 0;
    if (mPos == seqQ.size() - 1) begin
      if (cycleCount != 0 && mCyc == 1) begin
        mRun = 0; mState = 0; return;
      end
      if (cycleCount != 0) mCyc--;
      mPos = (triangle && seqQ.size() > 1) ? 1 : 0;
    end else begin
      mPos++;
    end
    mFreq = seqQ[mPos];
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFreq = '0; mRun = 0; mState = 0; mPin = 3'b111; mDwell = 0;
    end else begin
      logic fall, evt;
      int   limit;
      fall  = mPin[2] & ~mPin[1];
      mPin  = {mPin[1:0], trigPin};
      evt   = hwTrigSel ? fall : softTrig;
      limit = TPU * ((dwellUnits == 0) ? 1 : int'(dwellUnits));
      case (mState)
        0: if (evt && (hwTrigSel || !stepOnTrig)) begin
             buildSeq();
             mPos = 0; mFreq = seqQ[0]; mRun = 1; mCyc = int'(cycleCount);
             mDwell = 0; mState = stepOnTrig ? 2 : 1;
           end
        1: if (evt) begin mRun = 0; mState = 0; end
           else if (mDwell == limit - 1) modelAdvance();
           else mDwell++;
        default: if (evt) modelAdvance();
      endcase
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      check(curReq, "freqOut vs model", freqOut, mFreq);
      check(curReq, "running vs model", {55'd0, running}, {55'd0, mRun});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseSoft();
    softTrig = 1; cyc(1); softTrig = 0;
  endtask

  task automatic writeList(int addr, logic [FW-1:0] data);
    listWrEn = 1; listWrAddr = AW'(addr); listWrData = data;
    refMem[addr] = data;
    cyc(1);
    listWrEn = 0;
  endtask

  task automatic pinFall();
    trigPin = 0; cyc(4); trigPin = 1; cyc(4);
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish();
  end

  initial begin
    logic [FW-1:0] held;
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    cyc(3);
    check("R1", "reset running", {55'd0, running}, '0);
    check("R1", "reset freqOut", freqOut, '0);
    rstN = 1;
    cyc(2);

    // R2: rising sawtooth ramp, two cycles
    curReq = "R2";
    startFreq = 1000; stopFreq = 1600; stepFreq = 250;
    dwellUnits = 1; cycleCount = 2; triangle = 0; listMode = 0;
    cyc(1); pulseSoft(); cyc(30);
    check("R7", "count done running", {55'd0, running}, '0);
    check("R2", "final rising point", freqOut, 1500);

    // R3: falling triangular ramp with zero dwell (R5 zero case)
    curReq = "R3";
    startFreq = 5000; stopFreq = 4000; stepFreq = 300;
    dwellUnits = 0; cycleCount = 1; triangle = 1;
    cyc(1); pulseSoft(); cyc(3);
    check("R3", "second falling point", freqOut, 4700);
    cyc(20);
    check("R6", "triangle returns to first", freqOut, 5000);
    check("R7", "single cycle done", {55'd0, running}, '0);

    // R5: dwell of 3 units at 2 ticks each holds a point for 6 cycles
    curReq = "R5";
    startFreq = 10; stopFreq = 100; stepFreq = 10;
    dwellUnits = 3; cycleCount = 0; triangle = 0;
    cyc(1); pulseSoft(); cyc(5);
    check("R5", "point held through dwell", freqOut, 10);
    cyc(1);
    check("R5", "point advanced after dwell", freqOut, 20);
    pulseSoft(); cyc(2);

    // R4 / R8: list triangle from the trigger pin
    curReq = "R4";
    writeList(0, 7000); writeList(1, 7100); writeList(2, 7250);
    writeList(3, 7050); writeList(4, 7300); writeList(5, 9999);
    listMode = 1; listLen = 5; triangle = 1; dwellUnits = 2; cycleCount = 2;
    trigPin = 0; cyc(5);          // edge while the software source is selected
    hwTrigSel = 1; cyc(1);
    trigPin = 1; cyc(6);
    check("R8", "rising pin ignored", {55'd0, running}, '0);
    trigPin = 0; cyc(2);
    check("R8", "not yet through synchronizer", {55'd0, running}, '0);
    cyc(2);
    check("R8", "falling pin starts run", {55'd0, running}, 1);
    check("R4", "first list point", freqOut, 7000);
    cyc(100);
    check("R6", "list triangle ends on first", freqOut, 7000);
    check("R7", "list run done", {55'd0, running}, '0);

    // R9 / R7 forever: software start and stop, sawtooth list
    curReq = "R9";
    hwTrigSel = 0; trigPin = 1; triangle = 0; listLen = 3;
    dwellUnits = 1; cycleCount = 0;
    cyc(4); pulseSoft(); cyc(60);
    check("R7", "zero count keeps running", {55'd0, running}, 1);
    pulseSoft(); cyc(1);
    check("R9", "second trigger stops", {55'd0, running}, '0);
    held = freqOut;
    cyc(10);
    check("R9", "output held after stop", freqOut, held);

    // R10: step on pin edges
    curReq = "R10";
    hwTrigSel = 1; stepOnTrig = 1; cycleCount = 1;
    cyc(4);
    pinFall(); cyc(20);
    check("R10", "no dwell advance", freqOut, 7000);
    pinFall();
    check("R10", "first step", freqOut, 7100);
    pinFall();
    check("R10", "second step", freqOut, 7250);
    pinFall();
    check("R10", "cycle done after step", {55'd0, running}, '0);
    check("R10", "last point held", freqOut, 7250);

    // R11: software strobe has no effect in stepping mode
    curReq = "R11";
    hwTrigSel = 0; cyc(2);
    pulseSoft(); cyc(5);
    check("R11", "soft strobe ignored", {55'd0, running}, '0);
    check("R11", "output unchanged", freqOut, 7250);

    cyc(2);
    finish();
  end
endmodule